// File: doc/BRIEF.md
# H-Bridge Command Decoder with Timed Sleep

This block sits between a motor controller's two direction/PWM logic inputs and the gate drivers of a four-switch H-bridge. It resynchronises both inputs, decodes them into one of four bridge states (coast, forward, reverse, brake) and drives four gate enables, one high-side and one low-side per half-bridge. Whenever a half-bridge moves its output from one rail to the other, both of its switches are held off for a dead band of 220 ns, rounded up to whole clock cycles. This keeps the two switches of a leg from conducting together.

The block also runs a power state machine. It starts asleep out of reset. Two conditions wake it. First, at least one input must be high without a break for 5 µs. Then a 50 µs turn-on delay must elapse, after which the bridge is ready. Once ready, the block returns to sleep if both inputs stay low for 1 ms. A global enable from the fault logic removes all four gate enables in the same cycle it falls. All timers are cycle counters derived from the clock frequency parameter.

Top module: `hbd_bridge_ctrl`

## Requirements
- R1: While ready, inputs drive_a=0, drive_b=0 (coast) turn all four gate enables off.
- R2: While ready, drive_a=1, drive_b=0 (forward) settles to hs1=1, ls1=0, hs2=0, ls2=1.
- R3: While ready, drive_a=0, drive_b=1 (reverse) settles to hs1=0, ls1=1, hs2=1, ls2=0.
- R4: While ready, drive_a=1, drive_b=1 (brake) settles to ls1=1, ls2=1 with both high-side enables off.
- R5: When both inputs have been low for 1 ms (50000 cycles at 50 MHz), sleep_flag rises, ready falls and all gate enables are off. A low interval shorter than that leaves the block ready.
- R6: In the first cycle after reset is released the block is asleep (sleep_flag=1, ready=0, all gates off), with no 1 ms wait.
- R7: Sleep is left only after at least one input has been high for 5 µs (250 cycles) without a break. A shorter pulse leaves sleep_flag high.
- R8: ready rises 50 µs (2500 cycles) after sleep_flag falls. Until then all gate enables stay off.
- R9: A leg never has both its switches on. When a leg moves between high and low, both switches are off for ceil(220 ns × CLK_HZ) cycles (11 at 50 MHz) before the new switch turns on.
- R10: bridge_en=0 forces all four gate enables off in the same cycle. After bridge_en returns, the decoded state reappears one clock edge later.
- R11: An input change reaches the gate enables on the third rising clock edge after it, through a two-flop synchroniser and the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency given by CLK_HZ |
| rst | input | 1 | Synchronous active-high power-on reset |
| drive_a | input | 1 | First bridge command input, asynchronous |
| drive_b | input | 1 | Second bridge command input, asynchronous |
| bridge_en | input | 1 | Global enable from fault logic, low forces all switches off |
| hs1_o | output | 1 | High-side gate enable, leg 1 |
| ls1_o | output | 1 | Low-side gate enable, leg 1 |
| hs2_o | output | 1 | High-side gate enable, leg 2 |
| ls2_o | output | 1 | Low-side gate enable, leg 2 |
| sleep_o | output | 1 | High while in the low-power sleep state |
| ready_o | output | 1 | High once awake and the turn-on delay has finished |

## Verification
The assertions assume that reset is held for at least one clock at start-up. They also assume that each leg receives a single direction command at a time, which the decoder guarantees for every input pair. They do not depend on any minimum hold time of drive_a and drive_b, because the dead band is enforced by the leg counters whatever the input rate. The stimulus holds each random input pattern for at least 16 cycles, which exceeds synchroniser latency plus the dead band, so settled-state checks are well defined. The stimulus never lets a random coast interval approach the 1 ms sleep timer, so sleep entry happens only in the directed case.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } leg_cmd_e;

  typedef enum logic [1:0] {
    PW_SLEEP  = 2'd0,
    PW_TURNON = 2'd1,
    PW_ACTIVE = 2'd2
  } pwr_state_e;

  // Converts a duration in ns to clock cycles, rounding up, at least one cycle.
  function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                               input longint unsigned clk_hz);
    longint unsigned c;
    c = (ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 64'd0) c = 64'd1;
    return 32'(c);
  endfunction

endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/hbd_power.sv
module hbd_power
  import hbd_pkg::*;
#(
  parameter int unsigned WAKE_CYC = 250,
  parameter int unsigned TON_CYC  = 2500,
  parameter int unsigned IDLE_CYC = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic any_high_i,
  output logic sleep_o,
  output logic ready_o
);
  localparam int unsigned MAX_A = (WAKE_CYC > TON_CYC) ? WAKE_CYC : TON_CYC;
  localparam int unsigned MAXC  = (MAX_A > IDLE_CYC) ? MAX_A : IDLE_CYC;
  localparam int unsigned CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);
  localparam logic [CW-1:0] TON_LAST  = CW'(TON_CYC - 1);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYC - 1);

  pwr_state_e    st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PW_SLEEP;
      cnt_q <= '0;
    end else begin
      case (st_q)
        PW_SLEEP: begin
          if (any_high_i) begin
            if (cnt_q == WAKE_LAST) begin
              st_q  <= PW_TURNON;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end else begin
            cnt_q <= '0;
          end
        end
        PW_TURNON: begin
          if (cnt_q == TON_LAST) begin
            st_q  <= PW_ACTIVE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        PW_ACTIVE: begin
          if (!any_high_i) begin
            if (cnt_q == IDLE_LAST) begin
              st_q  <= PW_SLEEP;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end else begin
            cnt_q <= '0;
          end
        end
        default: begin
          st_q  <= PW_SLEEP;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign sleep_o = (st_q == PW_SLEEP);
  assign ready_o = (st_q == PW_ACTIVE);

  // R6: reset always lands in sleep
  a_r6_reset_sleep: assert property (@(posedge clk) rst |=> sleep_o);
  // R5: sleep is entered only after an idle input cycle
  a_r5_sleep_after_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_o) |-> $past(!any_high_i));
  // R7: leaving sleep never makes the bridge ready at once
  a_r7_wake_not_ready: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_o) |-> !ready_o);
  // R8: ready only follows the turn-on wait
  a_r8_ready_after_turnon: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $past(!sleep_o && !ready_o));
endmodule

// File: rtl/hbd_leg.sv
module hbd_leg
  import hbd_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 11
) (
  input  logic     clk,
  input  logic     rst,
  input  leg_cmd_e cmd_i,
  output logic     hs_o,
  output logic     ls_o
);
  localparam int unsigned   DW     = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_V = DW'(DEAD_CYC);

  logic          hs_q, ls_q, hs_n, ls_n;
  logic [DW-1:0] hs_off_q, ls_off_q;

  // A switch may close only once its partner has been open for the dead band.
  always_comb begin
    hs_n = (cmd_i == LEG_HIGH) && (ls_off_q == DEAD_V);
    ls_n = (cmd_i == LEG_LOW)  && (hs_off_q == DEAD_V);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q     <= 1'b0;
      ls_q     <= 1'b0;
      hs_off_q <= DEAD_V;
      ls_off_q <= DEAD_V;
    end else begin
      hs_q     <= hs_n;
      ls_q     <= ls_n;
      hs_off_q <= hs_n ? '0 : ((hs_off_q == DEAD_V) ? DEAD_V : hs_off_q + DW'(1));
      ls_off_q <= ls_n ? '0 : ((ls_off_q == DEAD_V) ? DEAD_V : ls_off_q + DW'(1));
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  // R9: never both switches of the leg on
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(hs_q && ls_q));
  // R9: a low-side on-cycle is never followed directly by high-side on
  a_r9_low_then_high: assert property (@(posedge clk) disable iff (rst)
    ls_q |=> !hs_q);
  // R9: a high-side on-cycle is never followed directly by low-side on
  a_r9_high_then_low: assert property (@(posedge clk) disable iff (rst)
    hs_q |=> !ls_q);
endmodule

// File: rtl/hbd_bridge_ctrl.sv
module hbd_bridge_ctrl
  import hbd_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned DEAD_NS    = 220,
  parameter int unsigned WAKE_NS    = 5_000,
  parameter int unsigned TURNON_NS  = 50_000,
  parameter int unsigned IDLE_NS    = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic drive_a,
  input  logic drive_b,
  input  logic bridge_en,
  output logic hs1_o,
  output logic ls1_o,
  output logic hs2_o,
  output logic ls2_o,
  output logic sleep_o,
  output logic ready_o
);
  localparam int unsigned DEAD_CYC = ns_to_cycles(64'(DEAD_NS),   64'(CLK_HZ));
  localparam int unsigned WAKE_CYC = ns_to_cycles(64'(WAKE_NS),   64'(CLK_HZ));
  localparam int unsigned TON_CYC  = ns_to_cycles(64'(TURNON_NS), 64'(CLK_HZ));
  localparam int unsigned IDLE_CYC = ns_to_cycles(64'(IDLE_NS),   64'(CLK_HZ));
  localparam int unsigned NLEGS    = 2;

  logic [1:0]       cmd_s;
  logic             sleep_w, ready_w;
  leg_cmd_e         leg_cmd [NLEGS];
  logic [NLEGS-1:0] hs_q, ls_q;

  hbd_sync #(.WIDTH(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({drive_a, drive_b}),
    .q_o (cmd_s)
  );

  hbd_power #(
    .WAKE_CYC (WAKE_CYC),
    .TON_CYC  (TON_CYC),
    .IDLE_CYC (IDLE_CYC)
  ) u_power (
    .clk        (clk),
    .rst        (rst),
    .any_high_i (|cmd_s),
    .sleep_o    (sleep_w),
    .ready_o    (ready_w)
  );

  // Truth table: leg 0 drives OUT1, leg 1 drives OUT2.
  always_comb begin
    leg_cmd[0] = LEG_OFF;
    leg_cmd[1] = LEG_OFF;
    if (ready_w && bridge_en) begin
      case (cmd_s)
        2'b10: begin leg_cmd[0] = LEG_HIGH; leg_cmd[1] = LEG_LOW;  end
        2'b01: begin leg_cmd[0] = LEG_LOW;  leg_cmd[1] = LEG_HIGH; end
        2'b11: begin leg_cmd[0] = LEG_LOW;  leg_cmd[1] = LEG_LOW;  end
        default: begin leg_cmd[0] = LEG_OFF; leg_cmd[1] = LEG_OFF; end
      endcase
    end
  end

  for (genvar g = 0; g < NLEGS; g++) begin : g_leg
    hbd_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk   (clk),
      .rst   (rst),
      .cmd_i (leg_cmd[g]),
      .hs_o  (hs_q[g]),
      .ls_o  (ls_q[g])
    );
  end

  // Enable masks the registered enables without waiting for a clock edge.
  assign hs1_o   = hs_q[0] & bridge_en;
  assign ls1_o   = ls_q[0] & bridge_en;
  assign hs2_o   = hs_q[1] & bridge_en;
  assign ls2_o   = ls_q[1] & bridge_en;
  assign sleep_o = sleep_w;
  assign ready_o = ready_w;

  // R8 / R5: outside the ready state the leg registers clear one edge later
  a_r8_off_when_not_ready: assert property (@(posedge clk) disable iff (rst)
    !ready_w |=> (hs_q == '0 && ls_q == '0));
  // R10: a low enable clears the leg registers on the next edge
  a_r10_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !bridge_en |=> (hs_q == '0 && ls_q == '0));
endmodule

// File: tb/hbd_bridge_ctrl_test.sv
`timescale 1ns/1ps
module hbd_bridge_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a = 1'b0, b = 1'b0, en = 1'b1;
  logic hs1, ls1, hs2, ls2, slp, rdy;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  always #10 clk = ~clk;

  hbd_bridge_ctrl uut (
    .clk (clk), .rst (rst), .drive_a (a), .drive_b (b), .bridge_en (en),
    .hs1_o (hs1), .ls1_o (ls1), .hs2_o (hs2), .ls2_o (ls2),
    .sleep_o (slp), .ready_o (rdy)
  );

  // Expected settled gates {hs1,ls1,hs2,ls2} from the truth table.
  function automatic logic [3:0] exp_gates(input logic ia, input logic ib);
    case ({ia, ib})
      2'b10:   return 4'b1001;
      2'b01:   return 4'b0110;
      2'b11:   return 4'b0101;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_gates(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {hs1, ls1, hs2, ls2};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gates actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed_ret;
    logic [1:0]  pat;
    int          hold;
    logic        overlap;
    seed_ret = $urandom(32'd20240611);

    // R6: reset released with inputs low -> asleep at once
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    step(1);
    chk_bit("R6 sleep after reset", slp, 1'b1);
    chk_bit("R6 ready after reset", rdy, 1'b0);
    chk_gates("R6 gates after reset", 4'b0000);

    // R7: a 100-cycle pulse is too short to wake
    @(negedge clk) a = 1'b1;
    step(100);
    @(negedge clk) a = 1'b0;
    step(300);
    chk_bit("R7 short pulse keeps sleep", slp, 1'b1);

    // R7/R8: sustained forward command wakes, then turn-on delay
    @(negedge clk) a = 1'b1;
    step(245);
    chk_bit("R7 still asleep before 5us", slp, 1'b1);
    step(15);
    chk_bit("R7 awake after 5us", slp, 1'b0);
    chk_bit("R8 not ready during turn-on", rdy, 1'b0);
    chk_gates("R8 gates off during turn-on", 4'b0000);
    step(2485);
    chk_bit("R8 not ready before 50us", rdy, 1'b0);
    step(15);
    chk_bit("R8 ready after 50us", rdy, 1'b1);
    chk_gates("R2 forward", 4'b1001);

    // R11 + R9 + R4: forward -> brake, leg 1 reverses through dead band
    @(negedge clk) b = 1'b1;
    step(2);
    chk_gates("R11 unchanged after two edges", 4'b1001);
    step(1);
    chk_gates("R11 high side off on third edge", 4'b0001);
    step(10);
    chk_gates("R9 dead band leg1 still open", 4'b0001);
    step(1);
    chk_gates("R4 brake after dead band", 4'b0101);

    // R9 + R3: brake -> reverse, leg 2 reverses
    @(negedge clk) a = 1'b0;
    step(13);
    chk_gates("R9 dead band leg2 still open", 4'b0100);
    step(1);
    chk_gates("R3 reverse after dead band", 4'b0110);

    // R1 + R5: coast, short idle keeps ready
    @(negedge clk) b = 1'b0;
    step(3);
    chk_gates("R1 coast", 4'b0000);
    step(1000);
    chk_bit("R5 short idle keeps ready", rdy, 1'b1);
    chk_bit("R5 short idle no sleep", slp, 1'b0);
    @(negedge clk) a = 1'b1;
    step(3);
    chk_gates("R11 coast to forward on third edge", 4'b1001);

    // R10: enable removes gates in the same cycle
    @(negedge clk) en = 1'b0;
    #1;
    chk_gates("R10 immediate off", 4'b0000);
    step(20);
    chk_gates("R10 held off", 4'b0000);
    @(negedge clk) en = 1'b1;
    step(1);
    chk_gates("R10 restored after one edge", 4'b1001);

    // Random patterns, R1/R2/R3/R4 settled values and R9 exclusion
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      pat  = 2'($urandom % 4);
      a    = pat[1];
      b    = pat[0];
      hold = 16 + int'($urandom % 24);
      overlap = 1'b0;
      for (int k = 0; k < hold; k++) begin
        @(posedge clk);
        #1;
        if ((hs1 && ls1) || (hs2 && ls2)) overlap = 1'b1;
      end
      chk_bit("R9 random no overlap", overlap, 1'b0);
      chk_gates("random truth table R1/R2/R3/R4", exp_gates(pat[1], pat[0]));
    end

    // R5: 1 ms of coast enters sleep
    @(negedge clk) begin a = 1'b0; b = 1'b0; end
    step(49990);
    chk_bit("R5 not asleep before 1ms", slp, 1'b0);
    step(20);
    chk_bit("R5 asleep after 1ms", slp, 1'b1);
    chk_bit("R5 ready low in sleep", rdy, 1'b0);
    chk_gates("R5 gates off in sleep", 4'b0000);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule